// File: doc/BRIEF.md
# Startup Timer, Watchdog and Stop-Mode Wake Controller

This block supervises the core of a small key-scanning remote-control transmitter. A single counter advances once per prescaler tick (one tick per `TICK_DIV` system clocks). After power-on, after a wake from stop, and after a watchdog expiry, the block holds the core in reset. It releases the core only once the counter has reached `2**START_W` ticks, which gives the oscillator time to settle. The core then starts at its reset address.

While the core runs, the same counter acts as a watchdog. The only thing that restarts it is a low-to-high transition of the transmit data bit, which the core drives. If no such edge arrives within `2**CNT_W` ticks, the block drops the core back into reset and repeats the startup delay.

A stop strobe from the core is accepted only when every key line is released. On acceptance the block turns the oscillator enable off and raises `stopped`. The port logic uses `stopped` to drive all row-scan outputs low and to make the transmit output inactive. The two single-bit scan outputs keep their values. Pulling any key line low wakes the block: the oscillator is re-enabled and the startup delay runs again. Key lines pass through two flops before they are used. `clk` is assumed to come from an always-on source, so the block itself keeps running while `osc_en` is low.

Top module: `wake_wdt_ctl`

## Requirements
- R1: While `por_n` is low, `core_rst_n` is 0, `osc_en` is 1 and `stopped` is 0.
- R2: `core_rst_n` rises exactly `2**START_W * TICK_DIV` clocks after `por_n` is released, and not earlier.
- R3: While running with no rising edge on `tx_data`, `core_rst_n` falls `2**CNT_W * TICK_DIV` clocks after release. The startup delay of R2 then repeats.
- R4: A clock edge that samples `tx_data` at 1 after sampling it at 0 on the previous edge restarts the watchdog interval from zero. Holding `tx_data` high, and driving it low, do not restart the interval.
- R5: A one-clock `stop_req` while running with all key lines high sets `stopped` to 1 and `osc_en` to 0 on that clock edge.
- R6: `stop_req` is ignored while any key line (active low) has been low for two or more clocks.
- R7: While stopped, a key line driven low makes `stopped` fall on the third clock edge. On that same edge `core_rst_n` is 0 and `osc_en` is 1. The core is released `2**START_W * TICK_DIV` clocks later.
- R8: While stopped, the watchdog does not advance. `core_rst_n` stays 1 and `stopped` stays 1 for as long as no key is pressed.
- R9: `stop_req` is ignored while the core is held in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on system clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| stop_req | input | 1 | One-clock stop request from the core |
| key_n | input | KEYS | Key sense lines, active low |
| tx_data | input | 1 | Transmit data bit; its rising edge refreshes the watchdog |
| core_rst_n | output | 1 | Core reset, active low |
| osc_en | output | 1 | Oscillator enable |
| stopped | output | 1 | High while in stop mode |

## Verification
The assertions on stop entry and wake compare the state change with the key lines as seen three clocks earlier. They therefore assume the key lines are high during and just after power-on reset, and that a key level is held for at least three clocks. The stimulus keeps every key line high through reset and holds each press for several clocks. Stop strobes are one clock wide and are kept apart from key edges, so each accept-or-ignore decision depends on a synchronised key level that has settled.

// File: rtl/wake_wdt_ctl.sv
module wake_wdt_ctl #(
  parameter int TICK_DIV = 12,
  parameter int CNT_W    = 13,
  parameter int START_W  = 10,
  parameter int KEYS     = 8
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            stop_req,
  input  logic [KEYS-1:0] key_n,
  input  logic            tx_data,
  output logic            core_rst_n,
  output logic            osc_en,
  output logic            stopped
);
  localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST   = PRE_W'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] START_LAST = CNT_W'((1 << START_W) - 1);
  localparam logic [CNT_W-1:0] CNT_LAST   = '1;

  typedef enum logic [1:0] {S_START, S_RUN, S_STOP} state_t;

  state_t          st;
  logic [KEYS-1:0] key_s1, key_s2;
  logic            tx_q;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;

  wire key_act    = ~&key_s2;
  wire tick       = (pre == PRE_LAST);
  wire tx_rise    = tx_data & ~tx_q;
  wire start_done = (st == S_START) && tick && (cnt == START_LAST);
  wire wd_expire  = (st == S_RUN) && tick && (cnt == CNT_LAST) && !tx_rise;
  wire go_stop    = (st == S_RUN) && stop_req && !key_act;
  wire wake       = (st == S_STOP) && key_act;
  wire refresh    = (st == S_RUN) && tx_rise;
  wire clr        = start_done | wd_expire | go_stop | wake | refresh;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      key_s1 <= '1;
      key_s2 <= '1;
      tx_q   <= 1'b0;
    end else begin
      key_s1 <= key_n;
      key_s2 <= key_s1;
      tx_q   <= tx_data;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st <= S_START;
    end else begin
      if (start_done)     st <= S_RUN;
      else if (wd_expire) st <= S_START;
      else if (go_stop)   st <= S_STOP;
      else if (wake)      st <= S_START;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (clr) begin
      pre <= '0;
      cnt <= '0;
    end else if (st != S_STOP) begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) cnt <= cnt + 1'b1;
    end
  end

  assign core_rst_n = (st != S_START);
  assign osc_en     = (st != S_STOP);
  assign stopped    = (st == S_STOP);
endmodule

// File: rtl/wake_wdt_ctl_chk.sv
module wake_wdt_ctl_chk #(
  parameter int KEYS = 8
) (
  input logic            clk,
  input logic            por_n,
  input logic            stop_req,
  input logic [KEYS-1:0] key_n,
  input logic            core_rst_n,
  input logic            osc_en,
  input logic            stopped
);
  a_r5_stop_on_request: assert property (@(posedge clk) disable iff (!por_n)
    $rose(stopped) |-> $past(stop_req) && $past(core_rst_n) && !osc_en);

  a_r6_stop_needs_idle_keys: assert property (@(posedge clk) disable iff (!por_n)
    $rose(stopped) |-> $past(&key_n, 3));

  a_r7_wake_into_reset: assert property (@(posedge clk) disable iff (!por_n)
    $fell(stopped) |-> !core_rst_n && osc_en);

  a_r7_wake_needs_key: assert property (@(posedge clk) disable iff (!por_n)
    $fell(stopped) |-> !$past(&key_n, 3));

  a_r8_no_reset_in_stop: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(core_rst_n) && $past(stopped)) |-> !$past(&key_n, 3));

  a_r2_release_running: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst_n) |-> osc_en && !stopped);

  a_r9_no_stop_in_reset: assert property (@(posedge clk) disable iff (!por_n)
    !core_rst_n |=> !stopped || !core_rst_n);
endmodule

bind wake_wdt_ctl wake_wdt_ctl_chk #(.KEYS(KEYS)) i_chk (
  .clk(clk), .por_n(por_n), .stop_req(stop_req), .key_n(key_n),
  .core_rst_n(core_rst_n), .osc_en(osc_en), .stopped(stopped)
);

// File: tb/test_wake_wdt_ctl.sv
module test_wake_wdt_ctl;
  localparam int DIV = 3, CW = 6, SW = 3, KEYS = 8;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic stop_req = 1'b0;
  logic [KEYS-1:0] key_n = '1;
  logic tx_data = 1'b0;
  logic core_rst_n, osc_en, stopped;

  int cyc = 0;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int    c;
    logic  r, o, s;
    string tag;
  } exp_t;
  exp_t q[$];

  wake_wdt_ctl #(.TICK_DIV(DIV), .CNT_W(CW), .START_W(SW), .KEYS(KEYS)) i_wake_wdt_ctl (
    .clk(clk), .por_n(por_n), .stop_req(stop_req), .key_n(key_n), .tx_data(tx_data),
    .core_rst_n(core_rst_n), .osc_en(osc_en), .stopped(stopped)
  );

  always #2 clk = ~clk;
  always @(posedge clk) if (por_n) cyc <= cyc + 1;

  task automatic check(string tag, logic r, logic o, logic s);
    n_run++;
    if ({core_rst_n, osc_en, stopped} !== {r, o, s}) begin
      n_fail++;
      $display("FAIL %s cyc=%0d rst/osc/stop actual=%b%b%b expected=%b%b%b",
               tag, cyc, core_rst_n, osc_en, stopped, r, o, s);
    end
  endtask

  task automatic expect_at(int c, logic r, logic o, logic s, string tag);
    exp_t e;
    int i = 0;
    e = '{c, r, o, s, tag};
    while (i < q.size() && q[i].c <= c) i++;
    q.insert(i, e);
  endtask

  task automatic wait_to(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      while (por_n && q.size() > 0 && q[0].c <= cyc) begin
        e = q.pop_front();
        if (e.c < cyc) begin
          n_run++;
          n_fail++;
          $display("FAIL %s missed sample cyc=%0d actual=none expected=at %0d", e.tag, cyc, e.c);
        end else begin
          check(e.tag, e.r, e.o, e.s);
        end
      end
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 1'b1, 1'b0);
    expect_at(23, 0, 1, 0, "R2 still held");
    expect_at(24, 1, 1, 0, "R2 release");
    expect_at(215, 1, 1, 0, "R3 before expiry");
    expect_at(216, 0, 1, 0, "R3 expiry");
    expect_at(239, 0, 1, 0, "R3 restart held");
    expect_at(240, 1, 1, 0, "R3 restart release");
    expect_at(492, 1, 1, 0, "R4 refreshed, level no refresh");
    expect_at(493, 0, 1, 0, "R4 expiry after refresh");
    expect_at(516, 0, 1, 0, "R4 held");
    expect_at(517, 1, 1, 0, "R4 release");
    expect_at(541, 1, 1, 0, "R6 stop ignored");
    expect_at(545, 1, 1, 0, "R6 stop ignored later");
    expect_at(560, 1, 1, 0, "R5 before stop");
    expect_at(561, 1, 0, 1, "R5 stop entered");
    expect_at(861, 1, 0, 1, "R8 still stopped");
    expect_at(872, 1, 0, 1, "R7 sync delay");
    expect_at(873, 0, 1, 0, "R7 wake");
    expect_at(881, 0, 1, 0, "R9 stop in reset");
    expect_at(882, 0, 1, 0, "R9 stop in reset later");
    expect_at(896, 0, 1, 0, "R7 startup held");
    expect_at(897, 1, 1, 0, "R7 startup release");
    por_n = 1'b1;

    wait_to(300); tx_data = 1'b1;
    wait_to(400); tx_data = 1'b0;
    wait_to(530); key_n[2] = 1'b0;
    wait_to(540); stop_req = 1'b1;
    wait_to(541); stop_req = 1'b0;
    wait_to(550); key_n[2] = 1'b1;
    wait_to(560); stop_req = 1'b1;
    wait_to(561); stop_req = 1'b0;
    wait_to(870); key_n[5] = 1'b0;
    wait_to(875); key_n[5] = 1'b1;
    wait_to(880); stop_req = 1'b1;
    wait_to(881); stop_req = 1'b0;
    wait_to(910);
    #2;
    n_run++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", q.size());
    end
    finish_run();
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    finish_run();
  end
endmodule